// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a real-time-clock peripheral. A prescaler divides the system clock into a timebase tick, 100 kHz by default. A reloadable down counter counts those ticks, and each time it wraps it raises a periodic interrupt. A processor reaches the block through a small 8-bit register port with two offsets. The same offset means a different register for a write than for a read. Offset 0 takes the start count on a write and gives back the live count on a read. Offset 1 takes the interrupt enable on a write and gives back the triggered flag on a read.

After a start count N is written, the counter steps down once per tick. When it has sat at zero for one tick, it reloads N and sets the triggered flag. Each period is therefore N+1 ticks long, so N = 199 at the default rate gives a 2 ms interrupt. The interrupt line is the flag masked by the enable. Software clears the flag by pulsing the acknowledge input or by reading offset 1.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the live count reads 0, the triggered flag and the enable are 0, and `irq` is low.
- R2: Until a start count is written, the counter stays idle: the count stays 0 and the flag is never set.
- R3: A write at offset 0 loads the start count and the live count in the same clock edge and restarts the timebase. A read at offset 0 returns the live count, combinationally, while `bus_sel` is high.
- R4: The live count decreases by one on each timebase tick. A tick occurs every CLK_HZ/TICK_HZ clocks, counted from reset or from the last offset-0 write.
- R5: On the tick that finds the count at zero, the counter reloads the start count and sets the triggered flag, and it keeps running. Flags therefore come every start+1 ticks, and a start count of 0 flags on every tick.
- R6: A write at offset 1 sets the enable from data bit 0. The other data bits have no effect.
- R7: A read at offset 1 returns the triggered flag in bit 0 with bits 7..1 zero, and that read clears the flag.
- R8: A high `irq_ack` at a clock edge clears the triggered flag.
- R9: `irq` is high exactly when both the triggered flag and the enable are set. With the enable clear, a pending flag stays readable but `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register offset (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_sel and !bus_we |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
Read data and `irq` are combinational from the registers. The bench samples them half a clock after it drives an access, before the edge that the access acts on. A write of start count N at edge P0 lands at P0, and the first decrement follows DIV edges later. The flag, and `irq` if enabled, rises exactly (N+1)·DIV edges after P0. Every bus task starts at a falling edge and covers exactly one rising edge, so the bench counts rising edges from P0 and checks `irq` one edge before and at that instant. It checks clears by acknowledge or read one edge after the pulse.

// File: rtl/timer_pkg.sv
// Shared constants for the periodic interrupt timer.
// Assumes an 8-bit data path and a one-bit register offset.
package timer_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 1;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 1'b0;  // start count (wr) / live count (rd)
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 1'b1;  // enable (wr) / triggered flag (rd)
endpackage

// File: rtl/tick_prescaler.sv
// Divides the system clock into a one-cycle tick every DIV clocks.
// A restart pulse zeroes the phase so the next tick is DIV clocks away.
// Assumes DIV >= 1; DIV == 1 yields a tick on every clock.
module tick_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase;

            // Phase counter: wraps at LAST, cleared by reset or restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) phase <= '0;
                else if (phase == LAST) phase <= '0;
                else phase <= phase + CW'(1);
            end

            assign tick = (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/reload_counter.sv
// Reloadable down counter. A load sets the start value and the count and arms it.
// While armed, each tick decrements; a tick at zero reloads and reports an event.
// Assumes load has priority over a coincident tick.
module reload_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] start,
    output logic         running,
    output logic         zero_evt
);
    // Counter state: start value, live count and armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            start   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            start   <= load_val;
            running <= 1'b1;
        end else if (tick && running) begin
            count <= (count == '0) ? start : count - W'(1);
        end
    end

    assign zero_evt = tick && running && !load && (count == '0);
endmodule

// File: rtl/timer_regs.sv
// Register port: decodes accesses, holds enable and triggered flag,
// muxes read data and forms the interrupt request.
// Assumes a read is any cycle with sel high and we low; reads return 0 otherwise.
module timer_regs
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              zero_evt,
    input  logic              ack,
    output logic              wr_start,
    output logic [DATA_W-1:0] rdata,
    output logic              enable,
    output logic              flag,
    output logic              irq
);
    logic rd_ctrl;

    assign wr_start = sel && we && (addr == OFS_COUNT);
    assign rd_ctrl  = sel && !we && (addr == OFS_CTRL);

    // Enable register: bit 0 of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) enable <= 1'b0;
        else if (sel && we && (addr == OFS_CTRL)) enable <= wdata[0];
    end

    // Triggered flag: set by a zero event, which wins over ack or read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else if (zero_evt) flag <= 1'b1;
        else if (ack || rd_ctrl) flag <= 1'b0;
    end

    // Read mux: live count or flag, zero when not reading.
    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            if (addr == OFS_COUNT) rdata = count;
            else rdata[0] = flag;
        end
    end

    assign irq = flag && enable;
endmodule

// File: rtl/periodic_tick_timer.sv
// Top of the periodic interrupt timer: prescaler, reload counter and register port.
// Assumes CLK_HZ is an integer multiple of TICK_HZ.
module periodic_tick_timer
    import timer_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic              tick;
    logic              wr_start;
    logic              zero_evt;
    logic              cnt_running;
    logic              enable;
    logic              flag;
    logic [DATA_W-1:0] cnt_value;
    logic [DATA_W-1:0] cnt_start;

    tick_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_start),
        .tick    (tick)
    );

    reload_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_start),
        .load_val (bus_wdata),
        .tick     (tick),
        .count    (cnt_value),
        .start    (cnt_start),
        .running  (cnt_running),
        .zero_evt (zero_evt)
    );

    timer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .count    (cnt_value),
        .zero_evt (zero_evt),
        .ack      (irq_ack),
        .wr_start (wr_start),
        .rdata    (bus_rdata),
        .enable   (enable),
        .flag     (flag),
        .irq      (irq)
    );
endmodule

// File: rtl/timer_checker.sv
// Protocol and state checks for periodic_tick_timer, attached by bind.
module timer_checker
    import timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_ack,
    input logic              irq,
    input logic              tick,
    input logic              cnt_running,
    input logic [DATA_W-1:0] cnt_value,
    input logic [DATA_W-1:0] cnt_start,
    input logic              enable,
    input logic              flag
);
    logic wr0;
    assign wr0 = bus_sel && bus_we && (bus_addr == OFS_COUNT);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_running |-> (cnt_value == '0 && !flag));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> (cnt_value == $past(bus_wdata) && cnt_start == $past(bus_wdata)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_running && !wr0 && cnt_value != '0) |=> cnt_value == $past(cnt_value) - DATA_W'(1));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_running && !wr0 && cnt_value == '0) |=> (flag && cnt_value == cnt_start));

    p_rd_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_CTRL) |-> bus_rdata[DATA_W-1:1] == '0);

    p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(tick && cnt_running && !wr0 && cnt_value == '0)) |=> !flag);

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq);
endmodule

bind periodic_tick_timer timer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_ack     (irq_ack),
    .irq         (irq),
    .tick        (tick),
    .cnt_running (cnt_running),
    .cnt_value   (cnt_value),
    .cnt_start   (cnt_start),
    .enable      (enable),
    .flag        (flag)
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;
    localparam int DIV = 4;          // 400 kHz / 100 kHz
    localparam int NV  = 5;
    localparam logic [7:0] START_TAB [NV] = '{8'd0, 8'd1, 8'd3, 8'd7, 8'd12};
    localparam int         TICKS_TAB [NV] = '{1, 2, 4, 8, 13};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [0:0] bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    periodic_tick_timer #(.CLK_HZ(400_000), .TICK_HZ(100_000)) i_periodic_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Each bus task starts at a falling edge and spans one rising edge.
    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(1'b0, rd); chk("R1 count", rd, 8'h00);
        bus_read(1'b1, rd); chk("R1 flag", rd, 8'h00);
        // R2: idle with no start count
        repeat (20) @(negedge clk);
        bus_read(1'b0, rd); chk("R2 count idle", rd, 8'h00);
        bus_read(1'b1, rd); chk("R2 flag idle", rd, 8'h00);

        // R6: enable on for the table
        bus_write(1'b1, 8'h01);

        // Table: period of start+1 ticks, then ack clears (R3 R5 R8 R9)
        for (int i = 0; i < NV; i++) begin
            bus_write(1'b0, START_TAB[i]);
            bus_read(1'b0, rd); chk("R3 load", rd, START_TAB[i]);
            repeat (TICKS_TAB[i] * DIV - 2) @(negedge clk);
            chk("R5 irq early", {7'b0, irq}, 8'h00);
            @(negedge clk);
            chk("R5 R9 irq on time", {7'b0, irq}, 8'h01);
            pulse_ack();
            chk("R8 ack clears", {7'b0, irq}, 8'h00);
        end

        // R4: one decrement per DIV clocks
        bus_write(1'b0, 8'd5);
        repeat (DIV) @(negedge clk);
        bus_read(1'b0, rd); chk("R4 first step", rd, 8'd4);
        repeat (DIV - 1) @(negedge clk);
        bus_read(1'b0, rd); chk("R4 second step", rd, 8'd3);
        // R3: rewrite reloads at once
        bus_write(1'b0, 8'd9);
        bus_read(1'b0, rd); chk("R3 reload now", rd, 8'd9);

        // R6 R9 R7: masking, read-back and read-clear
        bus_write(1'b1, 8'hFE);
        bus_write(1'b0, 8'd2);
        repeat (3 * DIV) @(negedge clk);
        chk("R9 masked irq", {7'b0, irq}, 8'h00);
        bus_read(1'b1, rd); chk("R7 flag read", rd, 8'h01);
        bus_read(1'b1, rd); chk("R7 read cleared", rd, 8'h00);
        bus_write(1'b1, 8'h01);
        chk("R9 enable no flag", {7'b0, irq}, 8'h00);
        repeat (3 * DIV - 3) @(negedge clk);
        chk("R6 R9 irq enabled", {7'b0, irq}, 8'h01);
        bus_write(1'b1, 8'h00);
        chk("R6 R9 disabled", {7'b0, irq}, 8'h00);
        bus_read(1'b1, rd); chk("R7 flag kept", rd, 8'h01);

        // R5: free running reloads
        bus_write(1'b1, 8'h01);
        bus_write(1'b0, 8'd1);
        repeat (2 * DIV) @(negedge clk);
        chk("R5 first period", {7'b0, irq}, 8'h01);
        pulse_ack();
        chk("R8 ack", {7'b0, irq}, 8'h00);
        repeat (2 * DIV - 2) @(negedge clk);
        chk("R5 before second", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R5 second period", {7'b0, irq}, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule